// File: doc/BRIEF.md
# Mirrored Nearest-Neighbour Region Downscaler

This block takes a face rectangle, given as inclusive top-left and bottom-right pixel coordinates, and selects one of the two upper quarters of that rectangle. The upper-left quarter serves the left eye and the upper-right quarter serves the right eye. It reads the chosen quarter from a single-port frame memory at one pixel per clock. It resamples the quarter to one of four fixed target sizes with nearest-neighbour selection, and it emits every resampled pixel on a write port together with its row and column. The write port feeds a small local array.

For the right-eye quarter, source columns are visited from the right edge of the face toward the centre. The stored image therefore already has the same orientation as a left-eye image, and no separate flip pass or flip buffer is needed. The step between source samples is a fixed-point ratio with eight fractional bits. A serial divider computes it once per run, and the per-pixel work is an accumulate.

A run begins with a one-cycle start pulse while the block is idle. The block stays busy until the last pixel is written, and it then gives a one-cycle done pulse. The read latency of the frame memory is a parameter of one or two cycles.

Top module: `rds_region_downscaler`

## Requirements
- R1: While reset is asserted and after it is released, until a start is accepted, busy, done, mem_rd and dst_we are all 0.
- R2: A start pulse seen while idle latches side, size_sel and the four face coordinates, and busy reads 1 in the following cycle.
- R3: The half width is floor((x1-x0+1)/2) and the half height is floor((y1-y0+1)/2). Source rows start at y0. The left quarter (side=0) starts at column x0, and the right quarter (side=1) ends at column x1.
- R4: With half size Q and target size T on an axis, step = floor(Q*256/T). Output index k on that axis takes source offset floor(k*step/256). For side=0, column offset o reads column x0+o.
- R5: For side=1, output column j reads source column x1 minus the column offset of j, so output column 0 comes from column x1.
- R6: The encoding of size_sel, given as width x height, is: 0 gives 33x36, 1 gives 31x34, 2 gives 29x32 and 3 gives 27x29. A run writes exactly width*height pixels.
- R7: Pixels are written in row-major order: dst_col runs 0..width-1 within each dst_row, and dst_row runs 0..height-1. dst_we is asserted only while busy.
- R8: Each read presents mem_addr = row*FRAME_W + column with mem_rd=1. The value returned RD_LAT cycles later is written with the row and column of that read.
- R9: done is a single-cycle pulse in the cycle after the last write. busy is 0 in that cycle.
- R10: A start pulse seen while busy is ignored. The running job keeps its latched parameters and its pixel count, and no second job follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle run request |
| side | input | 1 | 0 selects the upper-left quarter, 1 selects the upper-right quarter (mirrored) |
| size_sel | input | 2 | Target size code (see R6) |
| face_x0 | input | COORD_W | Face left column |
| face_y0 | input | COORD_W | Face top row |
| face_x1 | input | COORD_W | Face right column (inclusive) |
| face_y1 | input | COORD_W | Face bottom row (inclusive) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| mem_rd | output | 1 | Frame memory read strobe |
| mem_addr | output | ADDR_W | Frame memory address |
| mem_rdata | input | PIX_W | Pixel returned RD_LAT cycles after the read |
| dst_we | output | 1 | Resampled pixel valid |
| dst_row | output | 6 | Destination row |
| dst_col | output | 6 | Destination column |
| dst_data | output | PIX_W | Destination pixel |

## Verification
The in-line properties check, on every cycle, the control behaviour of the block. They cover acceptance of a start only when idle, the stability of the latched face parameters while a start arrives during a run, the rule that done never coincides with busy, the rule that writes happen only during a run, the alignment of each write with a read issued RD_LAT cycles earlier, and the bounds that keep source offsets inside the selected quarter. Only the bench scenarios can show that the right pixels land in the right places. Those cover the fixed-point step values, floor rounding on odd face sizes, the mirrored column order of the right quarter, upscaling when the quarter is smaller than the target, and the exact pixel count for each size code. The bench shows them by comparing every written pixel against a memory whose content is a known function of the address.

// File: rtl/rds_pkg.sv
package rds_pkg;

  localparam int FRAC_W = 8;
  localparam int SIZE_W = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DIV   = 2'd1,
    ST_RUN   = 2'd2,
    ST_DRAIN = 2'd3
  } rds_state_e;

  function automatic logic [SIZE_W-1:0] tgt_width(input logic [1:0] sel);
    case (sel)
      2'd0:    return SIZE_W'(33);
      2'd1:    return SIZE_W'(31);
      2'd2:    return SIZE_W'(29);
      default: return SIZE_W'(27);
    endcase
  endfunction

  function automatic logic [SIZE_W-1:0] tgt_height(input logic [1:0] sel);
    case (sel)
      2'd0:    return SIZE_W'(36);
      2'd1:    return SIZE_W'(34);
      2'd2:    return SIZE_W'(32);
      default: return SIZE_W'(29);
    endcase
  endfunction

endpackage

// File: rtl/rds_step_div.sv
// Serial restoring divider: one quotient bit per clock.
module rds_step_div #(
  parameter int NUM_W = 18,
  parameter int DEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quot,
  output logic             done
);

  localparam int CNT_W = $clog2(NUM_W + 1);

  logic             run_q, run_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [DEN_W-1:0] rem_q, rem_n;
  logic [NUM_W-1:0] sh_q, sh_n;
  logic [NUM_W-1:0] quot_q, quot_n;
  logic             done_q, done_n;
  logic [DEN_W:0]   trial, diff;
  logic             ge;

  always_comb begin
    trial  = {rem_q, sh_q[NUM_W-1]};
    diff   = trial - {1'b0, den};
    ge     = (trial >= {1'b0, den});
    run_n  = run_q;
    cnt_n  = cnt_q;
    rem_n  = rem_q;
    sh_n   = sh_q;
    quot_n = quot_q;
    done_n = 1'b0;
    if (start) begin
      run_n  = 1'b1;
      cnt_n  = '0;
      rem_n  = '0;
      sh_n   = num;
      quot_n = '0;
    end else if (run_q) begin
      rem_n  = ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
      sh_n   = {sh_q[NUM_W-2:0], 1'b0};
      quot_n = {quot_q[NUM_W-2:0], ge};
      cnt_n  = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(NUM_W - 1)) begin
        run_n  = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      sh_q   <= '0;
      quot_q <= '0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_n;
      cnt_q  <= cnt_n;
      rem_q  <= rem_n;
      sh_q   <= sh_n;
      quot_q <= quot_n;
      done_q <= done_n;
    end
  end

  assign quot = quot_q;
  assign done = done_q;

  // R4
  div_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/rds_addr_gen.sv
// Output raster counters and fixed-point source position accumulators.
module rds_addr_gen
  import rds_pkg::*;
#(
  parameter int COORD_W = 10,
  parameter int NUM_W   = 18,
  parameter int FRAME_W = 640,
  parameter int ADDR_W  = 19
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               adv,
  input  logic [SIZE_W-1:0]  tw,
  input  logic [SIZE_W-1:0]  th,
  input  logic [NUM_W-1:0]   step_x,
  input  logic [NUM_W-1:0]   step_y,
  input  logic [COORD_W-1:0] x0,
  input  logic [COORD_W-1:0] y0,
  input  logic [COORD_W-1:0] x1,
  input  logic               side,
  input  logic [COORD_W-1:0] qw,
  output logic [ADDR_W-1:0]  addr,
  output logic [SIZE_W-1:0]  col_idx,
  output logic [SIZE_W-1:0]  row_idx,
  output logic               last
);

  logic [SIZE_W-1:0]  col_q, col_n, row_q, row_n;
  logic [NUM_W-1:0]   accx_q, accx_n, accy_q, accy_n;
  logic [COORD_W-1:0] sx, sy, col_abs, row_abs;
  logic               col_end;

  assign sx      = accx_q[NUM_W-1:FRAC_W];
  assign sy      = accy_q[NUM_W-1:FRAC_W];
  assign col_end = (col_q == tw - SIZE_W'(1));
  assign last    = col_end && (row_q == th - SIZE_W'(1));

  always_comb begin
    col_n  = col_q;
    row_n  = row_q;
    accx_n = accx_q;
    accy_n = accy_q;
    if (clr) begin
      col_n  = '0;
      row_n  = '0;
      accx_n = '0;
      accy_n = '0;
    end else if (adv) begin
      if (col_end) begin
        col_n  = '0;
        accx_n = '0;
        row_n  = row_q + SIZE_W'(1);
        accy_n = accy_q + step_y;
      end else begin
        col_n  = col_q + SIZE_W'(1);
        accx_n = accx_q + step_x;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      row_q  <= '0;
      accx_q <= '0;
      accy_q <= '0;
    end else begin
      col_q  <= col_n;
      row_q  <= row_n;
      accx_q <= accx_n;
      accy_q <= accy_n;
    end
  end

  // Mirroring: the right quarter walks leftward from its right edge.
  assign col_abs = side ? (x1 - sx) : (x0 + sx);
  assign row_abs = y0 + sy;
  assign addr    = ADDR_W'(row_abs) * ADDR_W'(FRAME_W) + ADDR_W'(col_abs);
  assign col_idx = col_q;
  assign row_idx = row_q;

  // R3
  src_in_quad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> ((qw == '0) || (sx < qw)));

  // R7
  row_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (row_q < th));

endmodule

// File: rtl/rds_align.sv
// Carries destination coordinates alongside the memory read latency.
module rds_align #(
  parameter int LAT   = 1,
  parameter int ROW_W = 6,
  parameter int COL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [ROW_W-1:0] in_row,
  input  logic [COL_W-1:0] in_col,
  output logic             out_valid,
  output logic [ROW_W-1:0] out_row,
  output logic [COL_W-1:0] out_col
);

  logic [LAT-1:0]            v_q;
  logic [LAT-1:0][ROW_W-1:0] r_q;
  logic [LAT-1:0][COL_W-1:0] c_q;

  generate
    for (genvar g = 0; g < LAT; g++) begin : g_stage
      if (g == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            v_q[0] <= 1'b0;
            r_q[0] <= '0;
            c_q[0] <= '0;
          end else begin
            v_q[0] <= in_valid;
            if (in_valid) begin
              r_q[0] <= in_row;
              c_q[0] <= in_col;
            end
          end
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            v_q[g] <= 1'b0;
            r_q[g] <= '0;
            c_q[g] <= '0;
          end else begin
            v_q[g] <= v_q[g-1];
            if (v_q[g-1]) begin
              r_q[g] <= r_q[g-1];
              c_q[g] <= c_q[g-1];
            end
          end
        end
      end
    end
  endgenerate

  assign out_valid = v_q[LAT-1];
  assign out_row   = r_q[LAT-1];
  assign out_col   = c_q[LAT-1];

  // R8
  align_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, LAT));

endmodule

// File: rtl/rds_region_downscaler.sv
module rds_region_downscaler
  import rds_pkg::*;
#(
  parameter int FRAME_W = 640,
  parameter int FRAME_H = 480,
  parameter int COORD_W = 10,
  parameter int PIX_W   = 8,
  parameter int RD_LAT  = 1,
  localparam int ADDR_W = $clog2(FRAME_W * FRAME_H),
  localparam int NUM_W  = COORD_W + FRAC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               side,
  input  logic [1:0]         size_sel,
  input  logic [COORD_W-1:0] face_x0,
  input  logic [COORD_W-1:0] face_y0,
  input  logic [COORD_W-1:0] face_x1,
  input  logic [COORD_W-1:0] face_y1,
  output logic               busy,
  output logic               done,
  output logic               mem_rd,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic [PIX_W-1:0]   mem_rdata,
  output logic               dst_we,
  output logic [SIZE_W-1:0]  dst_row,
  output logic [SIZE_W-1:0]  dst_col,
  output logic [PIX_W-1:0]   dst_data
);

  rds_state_e state_q, state_n;
  logic [COORD_W-1:0] x0_q, y0_q, x1_q, y1_q;
  logic               side_q;
  logic [1:0]         sel_q;
  logic               load;
  logic               div_go_q, div_go_n;
  logic               done_q, done_n;
  logic [1:0]         drain_q, drain_n;
  logic [COORD_W:0]   fw, fh;
  logic [COORD_W-1:0] qw, qh;
  logic [SIZE_W-1:0]  tw, th;
  logic [1:0][NUM_W-1:0]  div_num;
  logic [1:0][SIZE_W-1:0] div_den;
  logic [1:0][NUM_W-1:0]  div_quot;
  logic [1:0]             div_done;
  logic               gen_clr, gen_last;
  logic [SIZE_W-1:0]  gen_col, gen_row;
  logic [ADDR_W-1:0]  gen_addr;

  assign fw = {1'b0, x1_q} - {1'b0, x0_q} + 1'b1;
  assign fh = {1'b0, y1_q} - {1'b0, y0_q} + 1'b1;
  assign qw = fw[COORD_W:1];
  assign qh = fh[COORD_W:1];
  assign tw = tgt_width(sel_q);
  assign th = tgt_height(sel_q);

  assign div_num[0] = {qw, {FRAC_W{1'b0}}};
  assign div_num[1] = {qh, {FRAC_W{1'b0}}};
  assign div_den[0] = tw;
  assign div_den[1] = th;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_axis
      rds_step_div #(.NUM_W(NUM_W), .DEN_W(SIZE_W)) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_go_q),
        .num   (div_num[g]),
        .den   (div_den[g]),
        .quot  (div_quot[g]),
        .done  (div_done[g])
      );
    end
  endgenerate

  // Control sequence
  always_comb begin
    state_n  = state_q;
    div_go_n = 1'b0;
    done_n   = 1'b0;
    drain_n  = drain_q;
    load     = 1'b0;
    gen_clr  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          load     = 1'b1;
          div_go_n = 1'b1;
          state_n  = ST_DIV;
        end
      end
      ST_DIV: begin
        if (div_done[0]) begin
          gen_clr = 1'b1;
          state_n = ST_RUN;
        end
      end
      ST_RUN: begin
        if (gen_last) begin
          drain_n = '0;
          state_n = ST_DRAIN;
        end
      end
      default: begin
        if (drain_q == 2'(RD_LAT - 1)) begin
          done_n  = 1'b1;
          state_n = ST_IDLE;
        end else begin
          drain_n = drain_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      div_go_q <= 1'b0;
      done_q   <= 1'b0;
      drain_q  <= '0;
    end else begin
      state_q  <= state_n;
      div_go_q <= div_go_n;
      done_q   <= done_n;
      drain_q  <= drain_n;
    end
  end

  // Job parameters, captured only on an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x0_q   <= '0;
      y0_q   <= '0;
      x1_q   <= '0;
      y1_q   <= '0;
      side_q <= 1'b0;
      sel_q  <= '0;
    end else if (load) begin
      x0_q   <= face_x0;
      y0_q   <= face_y0;
      x1_q   <= face_x1;
      y1_q   <= face_y1;
      side_q <= side;
      sel_q  <= size_sel;
    end
  end

  rds_addr_gen #(
    .COORD_W (COORD_W),
    .NUM_W   (NUM_W),
    .FRAME_W (FRAME_W),
    .ADDR_W  (ADDR_W)
  ) i_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (gen_clr),
    .adv     (mem_rd),
    .tw      (tw),
    .th      (th),
    .step_x  (div_quot[0]),
    .step_y  (div_quot[1]),
    .x0      (x0_q),
    .y0      (y0_q),
    .x1      (x1_q),
    .side    (side_q),
    .qw      (qw),
    .addr    (gen_addr),
    .col_idx (gen_col),
    .row_idx (gen_row),
    .last    (gen_last)
  );

  assign mem_rd   = (state_q == ST_RUN);
  assign mem_addr = gen_addr;

  rds_align #(.LAT(RD_LAT), .ROW_W(SIZE_W), .COL_W(SIZE_W)) i_align (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (mem_rd),
    .in_row    (gen_row),
    .in_col    (gen_col),
    .out_valid (dst_we),
    .out_row   (dst_row),
    .out_col   (dst_col)
  );

  assign dst_data = mem_rdata;
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  // R10
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(x0_q) && $stable(x1_q) && $stable(y0_q)
                         && $stable(y1_q) && $stable(side_q) && $stable(sel_q)));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  write_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |-> (busy && (dst_col < tw) && (dst_row < th)));

endmodule

// File: tb/test_rds_region_downscaler.sv
module test_rds_region_downscaler;

  localparam int FW  = 640;
  localparam int FH  = 480;
  localparam int CW  = 10;
  localparam int PW  = 8;
  localparam int LAT = 2;
  localparam int AW  = $clog2(FW * FH);
  localparam int NV  = 6;

  // {side[42], sel[41:40], x0[39:30], y0[29:20], x1[19:10], y1[9:0]}
  localparam logic [42:0] VECS [NV] = '{
    {1'b0, 2'd0, 10'd100, 10'd50,  10'd199, 10'd149},  // left, 50x50 quarter
    {1'b1, 2'd0, 10'd100, 10'd50,  10'd199, 10'd149},  // right, mirrored
    {1'b1, 2'd1, 10'd10,  10'd10,  10'd80,  10'd90},   // odd face size
    {1'b0, 2'd2, 10'd300, 10'd200, 10'd363, 10'd263},  // 29x32
    {1'b1, 2'd3, 10'd500, 10'd300, 10'd639, 10'd479},  // right frame edge
    {1'b0, 2'd3, 10'd0,   10'd0,   10'd19,  10'd19}    // upscaling
  };

  logic          clk, rst_n, start, side;
  logic [1:0]    size_sel;
  logic [CW-1:0] face_x0, face_y0, face_x1, face_y1;
  logic          busy, done, mem_rd, dst_we;
  logic [AW-1:0] mem_addr;
  logic [PW-1:0] mem_rdata, dst_data;
  logic [5:0]    dst_row, dst_col;
  logic [AW-1:0] ma_q [LAT];

  int n_chk, n_bad;
  int e_side, e_sel, e_x0, e_y0, e_x1, e_y1, e_total;
  int wr_k;
  bit got_done, prev_done;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  rds_region_downscaler #(
    .FRAME_W (FW), .FRAME_H (FH), .COORD_W (CW), .PIX_W (PW), .RD_LAT (LAT)
  ) i_rds_region_downscaler (
    .clk (clk), .rst_n (rst_n), .start (start), .side (side), .size_sel (size_sel),
    .face_x0 (face_x0), .face_y0 (face_y0), .face_x1 (face_x1), .face_y1 (face_y1),
    .busy (busy), .done (done), .mem_rd (mem_rd), .mem_addr (mem_addr),
    .mem_rdata (mem_rdata), .dst_we (dst_we), .dst_row (dst_row),
    .dst_col (dst_col), .dst_data (dst_data)
  );

  function automatic logic [7:0] pix(input int a);
    return 8'((a * 37) ^ (a >> 7));
  endfunction

  // Frame memory model: content is a function of the address
  always_ff @(posedge clk) begin
    ma_q[0] <= mem_addr;
    for (int i = 1; i < LAT; i++) ma_q[i] <= ma_q[i-1];
  end
  assign mem_rdata = pix(int'(ma_q[LAT-1]));

  function automatic int tw_of(input int s);
    case (s) 0: return 33; 1: return 31; 2: return 29; default: return 27; endcase
  endfunction
  function automatic int th_of(input int s);
    case (s) 0: return 36; 1: return 34; 2: return 32; default: return 29; endcase
  endfunction

  function automatic int exp_addr(input int k);
    int w, h, qw, qh, stx, sty, r, c, ox, oy, col;
    w = tw_of(e_sel); h = th_of(e_sel);
    qw = (e_x1 - e_x0 + 1) / 2; qh = (e_y1 - e_y0 + 1) / 2;
    stx = (qw * 256) / w; sty = (qh * 256) / h;
    r = k / w; c = k % w;
    ox = (c * stx) / 256; oy = (r * sty) / 256;
    col = (e_side != 0) ? (e_x1 - ox) : (e_x0 + ox);
    return (e_y0 + oy) * FW + col;
  endfunction

  task automatic fail_msg(input string m);
    n_bad++;
    $display("FAIL %s", m);
  endtask

  // Output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (dst_we) begin
        if (wr_k >= e_total) begin
          n_chk++;
          fail_msg($sformatf("R7 extra write #%0d, actual row %0d col %0d, expected none (total %0d)",
                             wr_k, dst_row, dst_col, e_total));
        end else begin
          int w, a;
          w = tw_of(e_sel);
          n_chk++;
          if (int'(dst_row) != wr_k / w || int'(dst_col) != wr_k % w)
            fail_msg($sformatf("R7 write #%0d position actual %0d,%0d expected %0d,%0d",
                               wr_k, dst_row, dst_col, wr_k / w, wr_k % w));
          a = exp_addr(wr_k);
          n_chk++;
          if (dst_data != pix(a)) begin
            if (e_side != 0)
              fail_msg($sformatf("R3 R5 R8 write #%0d data actual %0h expected %0h (addr %0d)",
                                 wr_k, dst_data, pix(a), a));
            else
              fail_msg($sformatf("R3 R4 R8 write #%0d data actual %0h expected %0h (addr %0d)",
                                 wr_k, dst_data, pix(a), a));
          end
        end
        wr_k++;
      end
      if (done) begin
        n_chk++;
        if (busy || wr_k != e_total)
          fail_msg($sformatf("R6 R9 at done: busy %0b writes %0d, expected busy 0 writes %0d",
                             busy, wr_k, e_total));
        got_done = 1'b1;
      end
      if (done && prev_done) begin
        n_chk++;
        fail_msg("R9 done high two cycles, actual 1 expected 0");
      end
      prev_done = done;
    end
  end

  task automatic set_job(input logic [42:0] v);
    e_side = int'(v[42]); e_sel = int'(v[41:40]);
    e_x0 = int'(v[39:30]); e_y0 = int'(v[29:20]);
    e_x1 = int'(v[19:10]); e_y1 = int'(v[9:0]);
    e_total = tw_of(e_sel) * th_of(e_sel);
    wr_k = 0; got_done = 1'b0;
    side = v[42]; size_sel = v[41:40];
    face_x0 = v[39:30]; face_y0 = v[29:20]; face_x1 = v[19:10]; face_y1 = v[9:0];
  endtask

  task automatic pulse_start;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n_chk++;
    if (busy !== 1'b1) fail_msg($sformatf("R2 busy after start actual %0b expected 1", busy));
  endtask

  task automatic wait_done;
    while (!got_done) @(negedge clk);
    repeat (4) @(negedge clk);
    n_chk++;
    if (busy !== 1'b0 || mem_rd !== 1'b0)
      fail_msg($sformatf("R9 R10 after run busy %0b mem_rd %0b expected 0 0", busy, mem_rd));
  endtask

  initial begin
    n_chk = 0; n_bad = 0; wr_k = 0; e_total = 0; got_done = 1'b0; prev_done = 1'b0;
    e_side = 0; e_sel = 0; e_x0 = 0; e_y0 = 0; e_x1 = 0; e_y1 = 0;
    rst_n = 1'b0; start = 1'b0; side = 1'b0; size_sel = 2'd0;
    face_x0 = '0; face_y0 = '0; face_x1 = '0; face_y1 = '0;
    repeat (3) @(negedge clk);
    n_chk++;
    if ({busy, done, mem_rd, dst_we} !== 4'b0)
      fail_msg($sformatf("R1 in reset busy/done/rd/we actual %b expected 0000",
                         {busy, done, mem_rd, dst_we}));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    n_chk++;
    if ({busy, done, mem_rd, dst_we} !== 4'b0)
      fail_msg($sformatf("R1 after reset busy/done/rd/we actual %b expected 0000",
                         {busy, done, mem_rd, dst_we}));

    // Vector table walk
    for (int v = 0; v < NV; v++) begin
      set_job(VECS[v]);
      pulse_start();
      wait_done();
    end

    // R10: a start during a run changes nothing
    set_job(VECS[1]);
    pulse_start();
    repeat (40) @(negedge clk);
    side = 1'b0; size_sel = 2'd3;
    face_x0 = 10'd5; face_y0 = 10'd5; face_x1 = 10'd60; face_y1 = 10'd60;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n_chk++;
    if (busy !== 1'b1) fail_msg($sformatf("R10 busy after ignored start actual %0b expected 1", busy));
    wait_done();
    n_chk++;
    if (wr_k != e_total)
      fail_msg($sformatf("R10 writes actual %0d expected %0d", wr_k, e_total));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    fail_msg("watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule